// File: doc/BRIEF.md
# Sleep-State Power Plane Controller

This block follows the system through its sleep states (S0 working, S1 to S5 sleeping) and drives the control pins that a power subsystem needs. These are three active-low plane-shutoff outputs (one for S1/S2, one for S3, one for S4/S5), an enable for the 32.768 kHz suspend clock, an active-low suspend-warning output, a peripheral reset and a processor reset. In the working state it also raises a one-cycle SMI or SCI request when the power button is pressed.

Software enters a sleep state by pulsing `sleep_req` with a target level on `sleep_type`. The block asserts the suspend warning first. After `LEAD_CLKS` clocks it drops the matching plane output. A wake event or a button press brings the planes back up. The warning is then held for another `LEAD_CLKS` clocks once power-good is high, and after that the block returns to S0. If the button is held for `HOLD_TICKS` ticks of the 32.768 kHz strobe (four seconds by default), the block forces S5, and from then on only the button can wake it.

The states are RUN (S0), WARN (warning asserted, planes still up), DOWN (sleeping at the stored level) and RISE (planes restored, waiting out the lead). The transitions are:
- RUN to WARN on a valid request.
- WARN to DOWN when the lead timer ends.
- DOWN to RISE on a wake.
- RISE to RUN when the lead timer ends.
- Any state except DOWN-at-S5 to DOWN at S5 on button override.
- Resume-well reset to DOWN at S5.

Top module: `sleep_plane_ctrl`

## Requirements
- R1: `plane_s12_n` is low exactly while the block sleeps at level 1 or 2 (`sleep_type` 3'd1 or 3'd2); it is high in all other states.
- R2: `plane_s3_n` is low exactly while the block sleeps at level 3 (`sleep_type` 3'd3).
- R3: `plane_s45_n` is low exactly while the block sleeps at level 4 or 5 (3'd4, 3'd5). `susclk_en` is low only in those levels and high in S0 to S3, in the warning phase and in the wake phase.
- R4: In S0, a rising edge of `btn_level` produces, one clock later, a single-cycle pulse on `smi_req` when `sci_sel`=0 or on `sci_req` when `sci_sel`=1.
- R5: While sleeping, a rising edge of `btn_level` or a `wake_evt` strobe moves the block to the wake phase on the next clock, and all three plane outputs return high.
- R6: When the button is held for `HOLD_TICKS` ticks, the block enters S5 from S0 to S4 two clocks after the completing tick. After that override, `wake_evt` is ignored and only a button press wakes the block. A release before the count completes clears the count.
- R7: While `pwr_good` is low, `periph_rst_n` and `cpu_rst_n` are both low. When the resets are released on entering S0, `cpu_rst_n` rises one clock after `periph_rst_n`.
- R8: `sus_warn_n` falls `LEAD_CLKS` clocks before the plane output falls. On wake, the planes rise first and `sus_warn_n` rises `LEAD_CLKS` clocks after entering the wake phase, with that count starting only while `pwr_good` is high.
- R9: A low on `well_rst_n` puts the block in S5: `plane_s45_n` low, `susclk_en` low, `sus_warn_n` low, both resets low, no request pulses.
- R10: A `sleep_req` whose `sleep_type` is 0, 6 or 7 is ignored; the block stays in S0 with `sus_warn_n` high.
- R11: The resets are held low while the block sleeps at level 2 to 5 and during the wake phase from those levels. At level 1 they follow `pwr_good` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| well_rst_n | input | 1 | Resume-well reset, active low, asynchronous |
| pwr_good | input | 1 | Power-good level |
| btn_level | input | 1 | Synchronized power-button level, 1 = pressed |
| rtc_tick | input | 1 | One-clock strobe at 32.768 kHz |
| sleep_req | input | 1 | Software sleep-entry strobe |
| sleep_type | input | 3 | Target sleep level 1..5 |
| wake_evt | input | 1 | Wake-event strobe from other sources |
| sci_sel | input | 1 | 0 routes button requests to SMI, 1 to SCI |
| plane_s12_n | output | 1 | Plane shutoff for S1/S2, active low |
| plane_s3_n | output | 1 | Plane shutoff for S3, active low |
| plane_s45_n | output | 1 | Plane shutoff for S4/S5, active low |
| susclk_en | output | 1 | Suspend clock enable |
| sus_warn_n | output | 1 | Pending-suspend warning, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| smi_req | output | 1 | One-cycle SMI request |
| sci_req | output | 1 | One-cycle SCI request |

## Verification
The bench places the warning lead at its exact edge cycle. A timer off by one would drop a plane one clock early or late, or release the warning too soon. It walks every sleep level and checks that exactly one plane falls. A wrong level decode would cut the wrong rail or gate the suspend clock in S3. It also holds the button through an override and then sends a wake strobe. A design that forgot the override flag would wake on that strobe. Finally it drops power-good during a wake and in S0. A design that released the resets early, or released the processor together with the peripherals, would show the wrong reset values.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WARN = 2'd1,
        ST_DOWN = 2'd2,
        ST_RISE = 2'd3
    } pstate_t;

    localparam int LVL_W = 3;

    localparam logic [LVL_W-1:0] LVL_S0 = 3'd0;
    localparam logic [LVL_W-1:0] LVL_S1 = 3'd1;
    localparam logic [LVL_W-1:0] LVL_S2 = 3'd2;
    localparam logic [LVL_W-1:0] LVL_S3 = 3'd3;
    localparam logic [LVL_W-1:0] LVL_S4 = 3'd4;
    localparam logic [LVL_W-1:0] LVL_S5 = 3'd5;

    function automatic logic lvl_valid(input logic [LVL_W-1:0] l);
        return (l >= LVL_S1) && (l <= LVL_S5);
    endfunction

endpackage

// File: rtl/spc_btn_hold.sv
module spc_btn_hold #(
    parameter int HOLD_TICKS = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    input  logic tick,
    output logic press,
    output logic hold_done
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

    logic          btn_q;
    logic [CW-1:0] cnt_q;

    assign press = btn && !btn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            btn_q     <= 1'b0;
            cnt_q     <= '0;
            hold_done <= 1'b0;
        end else begin
            btn_q     <= btn;
            hold_done <= btn && tick && (cnt_q == LAST);
            if (!btn) begin
                cnt_q <= '0;
            end else if (tick && (cnt_q != FULL)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6: an override pulse only follows a held button
    a_r6_hold_needs_btn: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |-> $past(btn));

    // R6: the override pulse lasts a single clock
    a_r6_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |=> !hold_done);

endmodule

// File: rtl/spc_lead_timer.sv
module spc_lead_timer #(
    parameter int LEAD_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LEAD_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(LEAD_CLKS - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // R8: the lead never completes before it has run LEAD_CLKS cycles
    a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (LEAD_CLKS > 1)) |-> $past(run));

endmodule

// File: rtl/spc_plane_decode.sv
module spc_plane_decode
    import spc_pkg::*;
(
    input  logic             asleep,
    input  logic [LVL_W-1:0] lvl,
    output logic             s12_n,
    output logic             s3_n,
    output logic             s45_n,
    output logic             clk_en
);
    always_comb begin
        s12_n  = 1'b1;
        s3_n   = 1'b1;
        s45_n  = 1'b1;
        clk_en = 1'b1;
        if (asleep) begin
            unique case (lvl)
                LVL_S1, LVL_S2: s12_n = 1'b0;
                LVL_S3:         s3_n  = 1'b0;
                LVL_S4, LVL_S5: begin
                    s45_n  = 1'b0;
                    clk_en = 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R1 R2 R3: at most one plane is cut at a time
    always_comb begin
        a_r1_one_plane: assert ($countones({~s12_n, ~s3_n, ~s45_n}) <= 1);
    end

endmodule

// File: rtl/sleep_plane_ctrl.sv
module sleep_plane_ctrl
    import spc_pkg::*;
#(
    parameter int LEAD_CLKS  = 16,
    parameter int HOLD_TICKS = 131072
) (
    input  logic       clk,
    input  logic       well_rst_n,
    input  logic       pwr_good,
    input  logic       btn_level,
    input  logic       rtc_tick,
    input  logic       sleep_req,
    input  logic [2:0] sleep_type,
    input  logic       wake_evt,
    input  logic       sci_sel,
    output logic       plane_s12_n,
    output logic       plane_s3_n,
    output logic       plane_s45_n,
    output logic       susclk_en,
    output logic       sus_warn_n,
    output logic       periph_rst_n,
    output logic       cpu_rst_n,
    output logic       smi_req,
    output logic       sci_req
);
    pstate_t          st_q, st_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic             ovr_q, ovr_d;
    logic             press, hold_done, lead_run, lead_done;
    logic             run_ok, rel_q;

    spc_btn_hold #(.HOLD_TICKS(HOLD_TICKS)) u_btn (
        .clk      (clk),
        .rst_n    (well_rst_n),
        .btn      (btn_level),
        .tick     (rtc_tick),
        .press    (press),
        .hold_done(hold_done)
    );

    assign lead_run = (st_q == ST_WARN) || ((st_q == ST_RISE) && pwr_good);

    spc_lead_timer #(.LEAD_CLKS(LEAD_CLKS)) u_lead (
        .clk  (clk),
        .rst_n(well_rst_n),
        .run  (lead_run),
        .done (lead_done)
    );

    spc_plane_decode u_dec (
        .asleep(st_q == ST_DOWN),
        .lvl   (lvl_q),
        .s12_n (plane_s12_n),
        .s3_n  (plane_s3_n),
        .s45_n (plane_s45_n),
        .clk_en(susclk_en)
    );

    // state register
    always_ff @(posedge clk or negedge well_rst_n) begin
        if (!well_rst_n) begin
            st_q  <= ST_DOWN;
            lvl_q <= LVL_S5;
            ovr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            lvl_q <= lvl_d;
            ovr_q <= ovr_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        lvl_d = lvl_q;
        ovr_d = ovr_q;
        unique case (st_q)
            ST_RUN: begin
                if (hold_done) begin
                    st_d = ST_DOWN; lvl_d = LVL_S5; ovr_d = 1'b1;
                end else if (sleep_req && lvl_valid(sleep_type)) begin
                    st_d = ST_WARN; lvl_d = sleep_type;
                end
            end
            ST_WARN: begin
                if (hold_done) begin
                    st_d = ST_DOWN; lvl_d = LVL_S5; ovr_d = 1'b1;
                end else if (lead_done) begin
                    st_d = ST_DOWN;
                end
            end
            ST_DOWN: begin
                if (hold_done && (lvl_q != LVL_S5)) begin
                    lvl_d = LVL_S5; ovr_d = 1'b1;
                end else if (press || (wake_evt && !ovr_q)) begin
                    st_d = ST_RISE;
                end
            end
            ST_RISE: begin
                if (hold_done) begin
                    st_d = ST_DOWN; lvl_d = LVL_S5; ovr_d = 1'b1;
                end else if (lead_done) begin
                    st_d = ST_RUN; lvl_d = LVL_S0; ovr_d = 1'b0;
                end
            end
            default: st_d = ST_DOWN;
        endcase
    end

    // outputs
    assign sus_warn_n   = (st_q == ST_RUN);
    assign run_ok       = (st_q == ST_RUN) || (st_q == ST_WARN) || (lvl_q == LVL_S1);
    assign periph_rst_n = pwr_good && run_ok;
    assign cpu_rst_n    = periph_rst_n && rel_q;

    always_ff @(posedge clk or negedge well_rst_n) begin
        if (!well_rst_n) begin
            smi_req <= 1'b0;
            sci_req <= 1'b0;
            rel_q   <= 1'b0;
        end else begin
            smi_req <= (st_q == ST_RUN) && press && !sci_sel;
            sci_req <= (st_q == ST_RUN) && press && sci_sel;
            rel_q   <= periph_rst_n;
        end
    end

    // R8: a plane is only cut after a warning phase or an override
    a_r8_warn_first: assert property (@(posedge clk) disable iff (!well_rst_n)
        ((st_q == ST_DOWN) && ($past(st_q) == ST_WARN)) |-> $past(!sus_warn_n));

    // R3: suspend clock is stopped only with the S4/S5 plane cut
    a_r3_clk_gate: assert property (@(posedge clk) disable iff (!well_rst_n)
        !susclk_en |-> !plane_s45_n);

    // R7: losing power-good holds both resets
    a_r7_pg_reset: assert property (@(posedge clk) disable iff (!well_rst_n)
        !pwr_good |-> (!periph_rst_n && !cpu_rst_n));

    // R7: processor never leaves reset before peripherals
    a_r7_cpu_after: assert property (@(posedge clk) disable iff (!well_rst_n)
        $rose(cpu_rst_n) |-> $past(periph_rst_n));

    // R4: requests are single-cycle and exclusive
    a_r4_pulse: assert property (@(posedge clk) disable iff (!well_rst_n)
        (smi_req || sci_req) |=> !(smi_req || sci_req));

    // R6: after an override a plain wake strobe does not wake
    a_r6_ovr_locks: assert property (@(posedge clk) disable iff (!well_rst_n)
        ((st_q == ST_DOWN) && ovr_q && !press && !hold_done) |=> (st_q == ST_DOWN));

endmodule

// File: tb/tb_sleep_plane_ctrl.sv
module tb_sleep_plane_ctrl;
    localparam int LEAD = 4;
    localparam int HOLD = 12;

    typedef struct {
        int         cyc;
        logic [8:0] vec;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic well_rst_n = 1'b0, pwr_good = 1'b0, btn_level = 1'b0, rtc_tick = 1'b1;
    logic sleep_req = 1'b0, wake_evt = 1'b0, sci_sel = 1'b0;
    logic [2:0] sleep_type = 3'd0;
    logic plane_s12_n, plane_s3_n, plane_s45_n, susclk_en, sus_warn_n;
    logic periph_rst_n, cpu_rst_n, smi_req, sci_req;

    int cnt = 0, checks = 0, failures = 0;
    bit done = 0;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    sleep_plane_ctrl #(.LEAD_CLKS(LEAD), .HOLD_TICKS(HOLD)) dut (
        .clk(clk), .well_rst_n(well_rst_n), .pwr_good(pwr_good), .btn_level(btn_level),
        .rtc_tick(rtc_tick), .sleep_req(sleep_req), .sleep_type(sleep_type),
        .wake_evt(wake_evt), .sci_sel(sci_sel), .plane_s12_n(plane_s12_n),
        .plane_s3_n(plane_s3_n), .plane_s45_n(plane_s45_n), .susclk_en(susclk_en),
        .sus_warn_n(sus_warn_n), .periph_rst_n(periph_rst_n), .cpu_rst_n(cpu_rst_n),
        .smi_req(smi_req), .sci_req(sci_req)
    );

    // order: s12,s3,s45,clk,warn,prst,crst,smi,sci
    function automatic logic [8:0] mk(input bit a, b, c, d, e, f, g, h, i);
        return {a, b, c, d, e, f, g, h, i};
    endfunction

    localparam logic [8:0] V_ON   = 9'b111_11_11_00;
    localparam logic [8:0] V_WARN = 9'b111_10_11_00;
    localparam logic [8:0] V_S5   = 9'b110_00_00_00;

    function automatic logic [8:0] v_sleep(input int l);
        return mk(!(l == 1 || l == 2), l != 3, l < 4, l < 4, 0, l == 1, l == 1, 0, 0);
    endfunction

    function automatic logic [8:0] v_rise(input int l);
        return mk(1, 1, 1, 1, 0, l == 1, l == 1, 0, 0);
    endfunction

    task automatic expect_at(input int d, input logic [8:0] v, input string r);
        exp_t e;
        e.cyc = cnt + d; e.vec = v; e.req = r;
        q.push_back(e);
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #2;
        end
    endtask

    // monitor: compare due expectations
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cnt) begin
            exp_t e;
            logic [8:0] obs;
            e = q.pop_front();
            obs = {plane_s12_n, plane_s3_n, plane_s45_n, susclk_en, sus_warn_n,
                   periph_rst_n, cpu_rst_n, smi_req, sci_req};
            checks++;
            if (obs !== e.vec || e.cyc != cnt) begin
                failures++;
                $display("FAIL %s cyc=%0d actual=%b expected=%b", e.req, cnt, obs, e.vec);
            end
        end
    end

    task automatic do_sleep(input int l, input string r);
        sleep_req = 1'b1; sleep_type = 3'(l);
        expect_at(1, V_WARN, r);
        expect_at(LEAD, V_WARN, "R8 lead");
        expect_at(LEAD + 1, v_sleep(l), r);
        tick_n(1);
        sleep_req = 1'b0;
        tick_n(LEAD + 2);
    endtask

    task automatic do_wake(input bit use_btn, input int l, input string r);
        if (use_btn) btn_level = 1'b1; else wake_evt = 1'b1;
        expect_at(1, v_rise(l), r);
        expect_at(LEAD, v_rise(l), "R8 wake lead");
        expect_at(LEAD + 1, mk(1, 1, 1, 1, 1, 1, l == 1, 0, 0), "R7 R8 wake exit");
        expect_at(LEAD + 2, V_ON, "R7 cpu release");
        tick_n(1);
        wake_evt = 1'b0;
        tick_n(LEAD + 2);
        btn_level = 1'b0;
        tick_n(2);
    endtask

    initial begin
        tick_n(3);
        well_rst_n = 1'b1;
        expect_at(1, V_S5, "R9 reset state");
        tick_n(2);
        // wake from S5 with power-good low: resets stay held
        wake_evt = 1'b1;
        expect_at(1, v_rise(5), "R5 R11 wake S5");
        expect_at(8, v_rise(5), "R7 R8 hold without pwr_good");
        tick_n(1);
        wake_evt = 1'b0;
        tick_n(9);
        pwr_good = 1'b1;
        expect_at(LEAD - 1, v_rise(5), "R8 pg lead");
        expect_at(LEAD, mk(1, 1, 1, 1, 1, 1, 0, 0, 0), "R7 periph first");
        expect_at(LEAD + 1, V_ON, "R7 cpu next");
        tick_n(LEAD + 3);
        // R4 SMI route
        btn_level = 1'b1;
        expect_at(1, mk(1, 1, 1, 1, 1, 1, 1, 1, 0), "R4 smi pulse");
        expect_at(2, V_ON, "R4 smi single");
        tick_n(3); btn_level = 1'b0; tick_n(2);
        // R4 SCI route
        sci_sel = 1'b1; btn_level = 1'b1;
        expect_at(1, mk(1, 1, 1, 1, 1, 1, 1, 0, 1), "R4 sci pulse");
        expect_at(2, V_ON, "R4 sci single");
        tick_n(3); btn_level = 1'b0; sci_sel = 1'b0; tick_n(2);
        // R10 invalid levels
        for (int t = 0; t < 8; t++) begin
            if (t >= 1 && t <= 5) continue;
            sleep_req = 1'b1; sleep_type = 3'(t);
            expect_at(1, V_ON, "R10 bad type");
            expect_at(3, V_ON, "R10 bad type later");
            tick_n(1); sleep_req = 1'b0; tick_n(3);
        end
        // walk levels
        do_sleep(1, "R1 S1 plane");  do_wake(0, 1, "R5 wake S1 evt");
        do_sleep(2, "R1 R11 S2");    do_wake(1, 2, "R5 wake S2 btn");
        do_sleep(3, "R2 R3 S3");     do_wake(0, 3, "R5 wake S3");
        do_sleep(4, "R3 S4");        do_wake(1, 4, "R5 wake S4");
        do_sleep(5, "R3 S5");        do_wake(0, 5, "R5 wake S5");
        // R6 short hold clears count
        btn_level = 1'b1;
        tick_n(HOLD - 3); btn_level = 1'b0; tick_n(1);
        btn_level = 1'b1;
        expect_at(HOLD - 2, V_ON, "R6 count cleared");
        tick_n(HOLD - 3); btn_level = 1'b0; tick_n(2);
        // R6 override from S0
        btn_level = 1'b1;
        expect_at(1, mk(1, 1, 1, 1, 1, 1, 1, 1, 0), "R4 R6 press");
        expect_at(HOLD, V_ON, "R6 before override");
        expect_at(HOLD + 1, V_S5, "R6 override S5");
        tick_n(HOLD + 3);
        btn_level = 1'b0;
        tick_n(2);
        wake_evt = 1'b1;
        expect_at(1, V_S5, "R6 evt ignored");
        expect_at(3, V_S5, "R6 evt ignored later");
        tick_n(1); wake_evt = 1'b0; tick_n(3);
        do_wake(1, 5, "R6 btn wakes");
        // R7 power-good loss in S0
        pwr_good = 1'b0;
        expect_at(1, mk(1, 1, 1, 1, 1, 0, 0, 0, 0), "R7 pg drop");
        tick_n(2);
        pwr_good = 1'b1;
        expect_at(1, V_ON, "R7 pg back");
        tick_n(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule